// File: doc/BRIEF.md
# Two-Stage Cascaded Clock Divider

This block divides an input clock by the product of two programmable integer ratios. Each of the two stages is set by a pair of 4-bit fields, one for the high part and one for the low part of its period. Either stage can be skipped on its own. The second stage counts whole periods of the first, so the overall period is the two stage ratios multiplied together. With both stages skipped, the input clock is passed straight through.

One channel-wide bit chooses how the high time is set. When the bit is clear (the state the block expects after configuration), the high time is balanced to half of the overall period. When the bit is set, the high time follows the high field of the last active stage. A single synchronous sync/reset input returns both stages and the output to a known phase, so several channels can be lined up.

All counting happens on the rising edge of the input clock. Each stage is a short registered counter followed by a compare, which keeps the logic depth small enough for very fast input clocks.

Top module: `div_cascade`

## Requirements
- R1: A stage that is not skipped divides by `high + low + 2`, where `high` and `low` are its 4-bit fields (each field holds a cycle count minus one). Each stage therefore covers ratios from 2 to 32. With the second stage skipped, `clk_out` repeats every `s1_high + s1_low + 2` input cycles.
- R2: With both stages active, the `clk_out` period is the product of the two stage ratios, up to 1024 input cycles. The second stage advances only at the end of a first-stage period.
- R3: A stage whose bypass bit is 1 acts as ratio 1 and holds its counter at zero. With only the first stage skipped, `clk_out` repeats every `s2_high + s2_low + 2` input cycles.
- R4: With both bypass bits at 1, `clk_out` equals `clk` (divide by 1). It reads 1 a quarter period after a rising edge and 0 at a falling edge.
- R5: With `duty_fix_off` = 1, `clk_out` is high for the first `s1_high + 1` input cycles of each period when the second stage is skipped. Otherwise it is high for `(s2_high + 1)` first-stage periods. A skipped first stage counts as a period of one input cycle.
- R6: With `duty_fix_off` = 0 and a single active stage of ratio R, `clk_out` is high for the first floor(R/2) input cycles of each period and low for the rest.
- R7: With `duty_fix_off` = 0 and both stages active, the single bit balances the whole cascade: `clk_out` is high for floor(R1 × R2 / 2) input cycles. For example, ratios 5 and 3 give 7 cycles high out of 15.
- R8: On a rising edge with `sync_rst` = 1, both counters clear and `clk_out` goes low (unless both stages are skipped). On the first rising edge after release, `clk_out` goes high, and a new period begins. A configuration applied together with sync takes effect from that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| sync_rst | input | 1 | Synchronous sync/reset, active high, restarts both stages |
| s1_high | input | 4 | First stage high count minus one |
| s1_low | input | 4 | First stage low count minus one |
| s2_high | input | 4 | Second stage high count minus one |
| s2_low | input | 4 | Second stage low count minus one |
| s1_bypass | input | 1 | 1 skips the first stage (ratio 1) |
| s2_bypass | input | 1 | 1 skips the second stage (ratio 1) |
| duty_fix_off | input | 1 | 1 turns off high-time balancing in both stages |
| clk_out | output | 1 | Divided clock |

## Verification
The divided output is registered. It shows the level for the counter position it had at a rising edge one edge later. The sync edge itself drives it low, and the edge after release drives it high. The bench model advances a behavioural position counter on each rising edge and compares it with `clk_out` at the following falling edge, half a period after the register has settled. Divide-by-1 is combinational. It is checked at the same falling edge (expecting 0) and again a quarter period after each rising edge (expecting 1). Configuration changes are always applied together with sync, so every expected value starts from position zero.

// File: rtl/div_cascade_pkg.sv
package div_cascade_pkg;

  // Ratio of one stage from its stored fields (each field is count minus one).
  function automatic int stage_ratio(input int high_f, input int low_f);
    return high_f + low_f + 2;
  endfunction

  // High length when balancing is on: floor of half the ratio.
  function automatic int balanced_high(input int ratio);
    return ratio / 2;
  endfunction

  // High length when balancing is off: the programmed high count.
  function automatic int raw_high(input int high_f);
    return high_f + 1;
  endfunction

endpackage

// File: rtl/div_stage.sv
module div_stage #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               sync_rst,
  input  logic               adv,
  input  logic [FIELD_W-1:0] hi_f,
  input  logic [FIELD_W-1:0] lo_f,
  input  logic               bypass,
  input  logic               fix_off,
  input  logic               half_in,
  output logic [FIELD_W:0]   cnt_o,
  output logic               wrap_o,
  output logic               level_o
);
  import div_cascade_pkg::*;

  localparam int CNT_W = FIELD_W + 1;
  localparam int RW    = FIELD_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [RW-1:0]    ratio;
  logic [RW-1:0]    last_pos;
  logic [RW-1:0]    knee;
  logic [RW-1:0]    cnt_ext;
  logic             at_end;
  logic             odd_tail;

  assign ratio    = RW'(stage_ratio(int'(hi_f), int'(lo_f)));
  assign last_pos = ratio - RW'(1);
  assign cnt_ext  = {1'b0, cnt};
  // Wrap on ">=" so a counter left beyond a newly shortened ratio recovers.
  assign at_end   = cnt_ext >= last_pos;

  assign knee = fix_off ? RW'(raw_high(int'(hi_f)))
                        : RW'(balanced_high(int'(ratio)));

  // Odd ratio with balancing: the position at the knee takes the upstream level.
  assign odd_tail = !fix_off && ratio[0] && (cnt_ext == knee) && half_in;

  assign level_o = !bypass && ((cnt_ext < knee) || odd_tail);
  assign wrap_o  = adv && (bypass || at_end);
  assign cnt_o   = cnt;

  always_ff @(posedge clk) begin
    if (sync_rst || bypass) begin
      cnt <= '0;
    end else if (adv) begin
      cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/div_out_stage.sv
module div_out_stage (
  input  logic clk,
  input  logic sync_rst,
  input  logic take_first,
  input  logic level_first,
  input  logic level_second,
  input  logic pass_clk,
  output logic q_o,
  output logic clk_out
);
  logic level_sel;
  logic div_q;

  assign level_sel = take_first ? level_first : level_second;

  always_ff @(posedge clk) begin
    if (sync_rst) begin
      div_q <= 1'b0;
    end else begin
      div_q <= level_sel;
    end
  end

  assign q_o     = div_q;
  assign clk_out = pass_clk ? clk : div_q;

endmodule

// File: rtl/div_cascade.sv
module div_cascade #(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               sync_rst,
  input  logic [FIELD_W-1:0] s1_high,
  input  logic [FIELD_W-1:0] s1_low,
  input  logic [FIELD_W-1:0] s2_high,
  input  logic [FIELD_W-1:0] s2_low,
  input  logic               s1_bypass,
  input  logic               s2_bypass,
  input  logic               duty_fix_off,
  output logic               clk_out
);
  localparam int CNT_W    = FIELD_W + 1;
  localparam int N_STAGES = 2;

  logic [FIELD_W-1:0] hi_v     [N_STAGES];
  logic [FIELD_W-1:0] lo_v     [N_STAGES];
  logic               byp_v    [N_STAGES];
  logic               adv_v    [N_STAGES];
  logic               half_v   [N_STAGES];
  logic [CNT_W-1:0]   cnt_v    [N_STAGES];
  logic               wrap_v   [N_STAGES];
  logic               level_v  [N_STAGES];

  // Named internal events for the checker.
  logic [CNT_W-1:0] s1_cnt;
  logic [CNT_W-1:0] s2_cnt;
  logic             s1_wrap;
  logic             s2_wrap;
  logic             div_q;

  assign hi_v[0]  = s1_high;
  assign hi_v[1]  = s2_high;
  assign lo_v[0]  = s1_low;
  assign lo_v[1]  = s2_low;
  assign byp_v[0] = s1_bypass;
  assign byp_v[1] = s2_bypass;

  // First stage runs every input cycle; second advances on first-stage wraps.
  assign adv_v[0]  = 1'b1;
  assign adv_v[1]  = wrap_v[0];
  assign half_v[0] = 1'b0;
  assign half_v[1] = level_v[0];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    div_stage #(.FIELD_W(FIELD_W)) u_stage (
      .clk      (clk),
      .sync_rst (sync_rst),
      .adv      (adv_v[g]),
      .hi_f     (hi_v[g]),
      .lo_f     (lo_v[g]),
      .bypass   (byp_v[g]),
      .fix_off  (duty_fix_off),
      .half_in  (half_v[g]),
      .cnt_o    (cnt_v[g]),
      .wrap_o   (wrap_v[g]),
      .level_o  (level_v[g])
    );
  end

  assign s1_cnt  = cnt_v[0];
  assign s2_cnt  = cnt_v[1];
  assign s1_wrap = wrap_v[0];
  assign s2_wrap = wrap_v[1];

  div_out_stage u_out (
    .clk          (clk),
    .sync_rst     (sync_rst),
    .take_first   (s2_bypass),
    .level_first  (level_v[0]),
    .level_second (level_v[1]),
    .pass_clk     (s1_bypass && s2_bypass),
    .q_o          (div_q),
    .clk_out      (clk_out)
  );

endmodule

// File: rtl/div_cascade_chk.sv
module div_cascade_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             sync_rst,
  input logic             s1_bypass,
  input logic             s2_bypass,
  input logic             s1_wrap,
  input logic             s2_wrap,
  input logic [CNT_W-1:0] s1_cnt,
  input logic [CNT_W-1:0] s2_cnt,
  input logic             div_q
);
  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (sync_rst) armed <= 1'b1;
  end

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!armed)
    sync_rst |=> (s1_cnt == '0 && s2_cnt == '0 && div_q == 1'b0)); // R8

  AST_S1_WRAP_CLEARS: assert property (@(posedge clk) disable iff (sync_rst || !armed)
    (s1_wrap && !s1_bypass) |=> (s1_cnt == '0)); // R1

  AST_S2_WAITS: assert property (@(posedge clk) disable iff (sync_rst || !armed)
    (!s1_wrap && !s2_bypass) |=> $stable(s2_cnt)); // R2

  AST_FRAME_END: assert property (@(posedge clk) disable iff (sync_rst || !armed)
    (s2_wrap && !s1_bypass && !s2_bypass) |=> (s1_cnt == '0 && s2_cnt == '0)); // R2

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!armed)
    s1_bypass |=> (s1_cnt == '0)); // R3

endmodule

bind div_cascade div_cascade_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .sync_rst  (sync_rst),
  .s1_bypass (s1_bypass),
  .s2_bypass (s2_bypass),
  .s1_wrap   (s1_wrap),
  .s2_wrap   (s2_wrap),
  .s1_cnt    (s1_cnt),
  .s2_cnt    (s2_cnt),
  .div_q     (div_q)
);

// File: tb/tb_div_cascade.sv
module tb_div_cascade;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       sync_rst = 1'b1;
  logic [3:0] s1_high = '0, s1_low = '0, s2_high = '0, s2_low = '0;
  logic       s1_bypass = 1'b0, s2_bypass = 1'b0, duty_fix_off = 1'b0;
  logic       clk_out;

  always #(CLK_P/2) clk = ~clk;

  div_cascade dut (
    .clk(clk), .sync_rst(sync_rst),
    .s1_high(s1_high), .s1_low(s1_low), .s2_high(s2_high), .s2_low(s2_low),
    .s1_bypass(s1_bypass), .s2_bypass(s2_bypass),
    .duty_fix_off(duty_fix_off), .clk_out(clk_out)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    pos    = 0;
  bit    armed  = 1'b0;
  bit    exp_q  = 1'b0;
  string tag    = "R8";

  // Reference: overall period and high length from the requirements.
  function automatic int first_len();
    return s1_bypass ? 1 : (int'(s1_high) + int'(s1_low) + 2);
  endfunction

  function automatic int period_len();
    int second_len;
    second_len = s2_bypass ? 1 : (int'(s2_high) + int'(s2_low) + 2);
    return first_len() * second_len;
  endfunction

  function automatic int high_len();
    if (duty_fix_off) begin
      if (s2_bypass) return int'(s1_high) + 1;
      return (int'(s2_high) + 1) * first_len();
    end
    return period_len() / 2;
  endfunction

  // Behavioural model: a position inside the overall period.
  always @(posedge clk) begin
    cyc++;
    if (sync_rst) begin
      pos   = 0;
      exp_q = 1'b0;
      armed = 1'b1;
    end else if (armed) begin
      exp_q = (pos < high_len());
      pos   = (pos + 1) % period_len();
    end
  end

  // Falling-edge comparison of the registered output.
  always @(negedge clk) begin
    if (armed) begin
      bit want;
      want = (s1_bypass && s2_bypass) ? 1'b0 : exp_q;
      checks++;
      if (clk_out !== want) begin
        fails++;
        $display("FAIL %s: clk_out=%0b expected %0b at cycle %0d", tag, clk_out, want, cyc);
      end
    end
  end

  // Divide-by-1 high phase check (R4).
  always @(posedge clk) begin
    if (armed && s1_bypass && s2_bypass && !sync_rst) begin
      #(CLK_P/4);
      checks++;
      if (clk_out !== 1'b1) begin
        fails++;
        $display("FAIL %s: clk_out=%0b expected 1 in high phase at cycle %0d", tag, clk_out, cyc);
      end
    end
  end

  task automatic setup(input string t, input int n1, input int m1, input int n2, input int m2,
                       input bit b1, input bit b2, input bit off);
    @(negedge clk); #1;
    tag          = t;
    s1_high      = 4'(n1);
    s1_low       = 4'(m1);
    s2_high      = 4'(n2);
    s2_low       = 4'(m2);
    s1_bypass    = b1;
    s2_bypass    = b2;
    duty_fix_off = off;
    sync_rst     = 1'b1;
    @(negedge clk); #1;
    sync_rst     = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync_pulse();
    @(negedge clk); #1;
    sync_rst = 1'b1;
    @(negedge clk); #1;
    sync_rst = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    // R8: reset state, output low after the sync edge.
    repeat (2) @(negedge clk);
    #1 sync_rst = 1'b0;
    run(4);
    // R1: single stage ratio 5, raw high 2.
    setup("R1", 1, 2, 0, 0, 0, 1, 1);    run(30);
    // R1: minimum ratio 2 with balancing.
    setup("R1_min", 0, 0, 0, 0, 0, 1, 0); run(12);
    // R6: single stage ratio 9 balanced (high 4), then ratio 32 (high 16).
    setup("R6", 4, 3, 0, 0, 0, 1, 0);    run(40);
    setup("R6_max", 15, 15, 0, 0, 0, 1, 0); run(100);
    // R5: raw high 7 of 8 with second stage skipped.
    setup("R5", 6, 0, 0, 0, 0, 1, 1);    run(40);
    // R3: first stage skipped, ratio 9 from the second stage.
    setup("R3", 0, 0, 3, 4, 1, 0, 0);    run(40);
    setup("R3_raw", 0, 0, 2, 1, 1, 0, 1); run(30);
    // R2: 5 x 3 = 15, raw high one first-stage period (R5 across stages).
    setup("R2", 2, 1, 0, 1, 0, 0, 1);    run(70);
    // R7: same ratios balanced, high 7 of 15.
    setup("R7", 2, 1, 0, 1, 0, 0, 0);    run(70);
    setup("R7_even", 1, 1, 2, 3, 0, 0, 0); run(80);
    // R2: maximum 32 x 32 = 1024.
    setup("R2_max", 15, 15, 15, 15, 0, 0, 0); run(2100);
    // R4: divide by 1.
    setup("R4", 0, 0, 0, 0, 1, 1, 0);    run(12);
    // R8: sync in the middle of a period restarts the phase.
    setup("R8", 2, 3, 0, 0, 0, 1, 1);    run(3);
    sync_pulse();                         run(20);
    setup("R8_cascade", 1, 0, 1, 1, 0, 0, 0); run(10);
    sync_pulse();                         run(30);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule